// File: doc/BRIEF.md
# Stop-Mode Wake and Clock Stabilization Controller

This block controls a small microcontroller core's low-power stop state. When the core issues a stop command, the block drops the core clock enable. It then waits in the stop state for a wake source. A byte-wide control register decides two things: whether the always-on RC watchdog may wake the part, and whether a watchdog event causes a reset or an interrupt. On any wake-up the block holds the core clock off while a stabilization timer runs, so that the restarted main oscillator can settle. It then releases the clock and tells the core how to continue: reset processing, an interrupt vector, or the next instruction after the stop command.

The controller is a four-state machine:
- RUN: the core is clocked.
- STOP: the core clock is gated.
- STABILIZE: the wait for the oscillator.
- RESUME: one cycle in which the clock returns and the continuation is signalled.

The transitions are:
- RUN→STOP on a stop command.
- STOP→STABILIZE on an accepted wake source.
- STABILIZE→RESUME when the timer expires.
- RESUME→RUN unconditionally.

Hardware reset places the machine in STABILIZE on the reset path. The timer has two modes:
- Reset-type exits use a fixed count of 2^FIX_LOG cycles.
- Interrupt-type exits use an 8-bit counter, from 00h up through FFh, advanced by a prescaler tap chosen in the control register. This stretches the wait to 256·2^tap cycles.

Wake inputs are asynchronous and each passes through a two-flop synchronizer.

Top module: `stop_wake_ctrl`

## Requirements
- R1: A stop_req seen in RUN moves the block to STOP on the next clock edge. core_clk_en is 0 from that edge on, and stays 0 until RESUME.
- R2: ext_wake is synchronized by two flops. A level raised in the stop state is seen as a wake after two edges. STABILIZE is entered on the third edge, and exit_cause then reads 2'b01.
- R3: On an interrupt-type wake, STABILIZE lasts exactly 256·2^tap cycles. Here tap is control bits [4:2]. core_clk_en returns to 1 in the following RESUME cycle.
- R4: wdt_event wakes the block only when control bit 0 (watchdog keeps running in stop) is 1. A watchdog event with bit 1 at 0 and wdt_ie at 0 is ignored, and the block stays in STOP.
- R5: A watchdog event with control bits 0 and 1 both at 1 takes the reset path. int_rst is 1 throughout a fixed stabilization of 2^FIX_LOG cycles, the control register is cleared to 00h, exit_cause reads 2'b10, and no resume_pulse is given.
- R6: While rst_n is low, and for 2^FIX_LOG cycles after it rises, int_rst is 1 and core_clk_en is 0. The control register reads 00h and exit_cause reads 2'b00.
- R7: resume_pulse is a single cycle, given in RESUME after interrupt-type wakes only. take_vector is 1 in that cycle exactly when gie was 1 at the wake. With gie at 0, the core resumes without a vector.
- R8: When several wake sources are present at once, the priority is watchdog-reset first, then external interrupt, then watchdog interrupt.
- R9: A write with reg_sel=0 replaces the whole control byte, but only in RUN. Writes in any other state are ignored. reg_rdata returns the control byte when reg_sel=0.
- R10: With reg_sel=1, reg_rdata returns {6'b0, exit_cause}. The cause codes are 00 reset, 01 external, 10 watchdog, and 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the controller |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: control byte, 1: exit-cause status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| gie | input | 1 | Global interrupt enable flag of the core |
| wdt_ie | input | 1 | Watchdog interrupt enable |
| stop_req | input | 1 | Stop command from the core |
| ext_wake | input | 1 | Asynchronous external interrupt wake source |
| wdt_event | input | 1 | Asynchronous RC watchdog event |
| core_clk_en | output | 1 | Core clock enable |
| int_rst | output | 1 | Internal reset to the core |
| resume_pulse | output | 1 | One-cycle strobe: continue after an interrupt-type wake |
| take_vector | output | 1 | With resume_pulse: branch to the interrupt vector |
| exit_cause | output | 2 | Cause of the last exit (00 reset, 01 external, 10 watchdog) |

## Verification
The hardest situation to reach is simultaneous wake sources in STOP. The priority decision depends on both synchronized levels arriving in the same cycle, together with the right control-byte setting. The bench raises ext_wake and wdt_event in the same cycle after programming the control byte during RUN. It does this once with watchdog-reset enabled and once with only watchdog-interrupt enabled. It then checks the measured stabilization length, int_rst and the cause code against the reference model on every clock. The ignored-watchdog case is reached by holding wdt_event in STOP for several cycles with the enables off, and confirming that the clock stays gated.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_STAB   = 2'd2,
        ST_RESUME = 2'd3
    } wake_state_e;

    typedef enum logic [1:0] {
        CAUSE_RESET = 2'b00,
        CAUSE_EXT   = 2'b01,
        CAUSE_WDOG  = 2'b10
    } exit_cause_e;

    // control byte field positions
    localparam int CTL_RC_KEEP  = 0;
    localparam int CTL_WD_RESET = 1;
    localparam int CTL_TAP_LO   = 2;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
    parameter int TAP_W   = 3,
    parameter int CNT_W   = 8,
    parameter int FIX_LOG = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fixed_mode,
    input  logic [TAP_W-1:0] tap,
    output logic             done
);
    localparam int PRE_W = (1 << TAP_W) - 1;

    logic [PRE_W-1:0]   pre_q;
    logic [PRE_W-1:0]   tap_mask;
    logic [CNT_W-1:0]   cnt_q;
    logic [FIX_LOG-1:0] fix_q;
    logic               tick;

    // divide by 2^tap: tick when the low tap bits of the prescaler are all ones
    assign tap_mask = ~({PRE_W{1'b1}} << tap);
    assign tick     = (pre_q & tap_mask) == tap_mask;
    assign done     = run && (fixed_mode ? (&fix_q) : (tick && (&cnt_q)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
            fix_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
            cnt_q <= '0;
            fix_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            fix_q <= fix_q + 1'b1;
            if (tick) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import stopwake_pkg::*;
#(
    parameter int TAP_W       = 3,
    parameter int CNT_W       = 8,
    parameter int FIX_LOG     = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       gie,
    input  logic       wdt_ie,
    input  logic       stop_req,
    input  logic       ext_wake,
    input  logic       wdt_event,
    output logic       core_clk_en,
    output logic       int_rst,
    output logic       resume_pulse,
    output logic       take_vector,
    output logic [1:0] exit_cause
);
    localparam int TAP_HI = CTL_TAP_LO + TAP_W - 1;

    wake_state_e      state_q, state_d;
    exit_cause_e      cause_q;
    logic [7:0]       ctl_q;
    logic             rst_path_q, vec_q;
    logic [1:0]       sync_out;
    logic             ext_s, wdt_s, timer_done;
    logic             wake_wrst, wake_ext, wake_wint;
    logic             rc_keep, wd_reset;
    logic [TAP_W-1:0] tap_sel;

    assign rc_keep  = ctl_q[CTL_RC_KEEP];
    assign wd_reset = ctl_q[CTL_WD_RESET];
    assign tap_sel  = ctl_q[TAP_HI:CTL_TAP_LO];

    wake_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({wdt_event, ext_wake}),
        .sync_out (sync_out)
    );
    assign ext_s = sync_out[0];
    assign wdt_s = sync_out[1];

    stab_timer #(.TAP_W(TAP_W), .CNT_W(CNT_W), .FIX_LOG(FIX_LOG)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (state_q == ST_STAB),
        .fixed_mode (rst_path_q),
        .tap        (tap_sel),
        .done       (timer_done)
    );

    // next state and wake classification
    always_comb begin
        state_d   = state_q;
        wake_wrst = 1'b0;
        wake_ext  = 1'b0;
        wake_wint = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (stop_req) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (wdt_s && rc_keep && wd_reset) wake_wrst = 1'b1;
                else if (ext_s)                   wake_ext  = 1'b1;
                else if (wdt_s && rc_keep && wdt_ie) wake_wint = 1'b1;
                if (wake_wrst || wake_ext || wake_wint) state_d = ST_STAB;
            end
            ST_STAB: begin
                if (timer_done) state_d = ST_RESUME;
            end
            ST_RESUME: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register with wake bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_STAB;
            rst_path_q <= 1'b1;
            cause_q    <= CAUSE_RESET;
            vec_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wake_wrst) begin
                rst_path_q <= 1'b1;
                cause_q    <= CAUSE_WDOG;
                vec_q      <= 1'b0;
            end else if (wake_ext || wake_wint) begin
                rst_path_q <= 1'b0;
                cause_q    <= wake_ext ? CAUSE_EXT : CAUSE_WDOG;
                vec_q      <= gie;
            end
        end
    end

    // control byte: whole-byte writes while running, cleared by watchdog reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wake_wrst) begin
            ctl_q <= '0;
        end else if (state_q == ST_RUN && reg_wr && !reg_sel) begin
            ctl_q <= reg_wdata;
        end
    end

    // outputs
    always_comb begin
        core_clk_en  = (state_q == ST_RUN) || (state_q == ST_RESUME);
        int_rst      = (state_q == ST_STAB) && rst_path_q;
        resume_pulse = (state_q == ST_RESUME) && !rst_path_q;
        take_vector  = resume_pulse && vec_q;
        exit_cause   = cause_q;
        reg_rdata    = reg_sel ? {6'b0, cause_q} : ctl_q;
    end
endmodule

// File: rtl/stop_wake_chk.sv
module stop_wake_chk
    import stopwake_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        stop_req,
    input wake_state_e state_q,
    input logic        core_clk_en,
    input logic        int_rst,
    input logic        resume_pulse,
    input logic        take_vector,
    input logic [1:0]  exit_cause
);
    assert_stop_gates_clk_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_req) |=> !core_clk_en);

    assert_stab_exits_resume_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STAB) |=> (state_q == ST_STAB || state_q == ST_RESUME));

    assert_clk_after_resume_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESUME) |=> core_clk_en);

    assert_rst_holds_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |-> !core_clk_en);

    assert_resume_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);

    assert_vector_with_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_vector |-> resume_pulse);

    assert_cause_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exit_cause != 2'b11);
endmodule

bind stop_wake_ctrl stop_wake_chk u_chk (.*);

// File: tb/sim_stop_wake_ctrl.sv
module sim_stop_wake_ctrl;
    localparam int RLOG = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       gie = 1'b0, wdt_ie = 1'b0, stop_req = 1'b0;
    logic       ext_wake = 1'b0, wdt_event = 1'b0;
    logic       core_clk_en, int_rst, resume_pulse, take_vector;
    logic [1:0] exit_cause;

    int    checks = 0, errors = 0, cycles = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R6";

    stop_wake_ctrl #(.FIX_LOG(RLOG)) u0 (.*);

    always #10 clk = ~clk;   // 50 MHz

    // behavioural reference model
    int       m_st = 2, m_cyc = 0, m_len = 1 << RLOG;
    bit       m_e1 = 0, m_e2 = 0, m_w1 = 0, m_w2 = 0, m_rp = 1, m_vec = 0;
    bit [7:0] m_ctl = 0;
    bit [1:0] m_cause = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 2; m_rp = 1; m_cyc = 0; m_len = 1 << RLOG;
            m_ctl = 0; m_cause = 0; m_vec = 0;
            m_e1 = 0; m_e2 = 0; m_w1 = 0; m_w2 = 0;
        end else begin
            case (m_st)
                0: begin
                    if (reg_wr && !reg_sel) m_ctl = reg_wdata;
                    if (stop_req) m_st = 1;
                end
                1: begin
                    if (m_w2 && m_ctl[0] && m_ctl[1]) begin
                        m_st = 2; m_rp = 1; m_cause = 2; m_vec = 0; m_ctl = 0;
                        m_cyc = 0; m_len = 1 << RLOG;
                    end else if (m_e2) begin
                        m_st = 2; m_rp = 0; m_cause = 1; m_vec = gie;
                        m_cyc = 0; m_len = 256 << m_ctl[4:2];
                    end else if (m_w2 && m_ctl[0] && wdt_ie) begin
                        m_st = 2; m_rp = 0; m_cause = 2; m_vec = gie;
                        m_cyc = 0; m_len = 256 << m_ctl[4:2];
                    end
                end
                2: begin
                    if (m_cyc == m_len - 1) m_st = 3;
                    else m_cyc++;
                end
                default: m_st = 0;
            endcase
            m_e2 = m_e1; m_e1 = ext_wake;
            m_w2 = m_w1; m_w1 = wdt_event;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            bit e_clk, e_rst, e_res, e_vec;
            bit [7:0] e_rd;
            e_clk = (m_st == 0) || (m_st == 3);
            e_rst = (m_st == 2) && m_rp;
            e_res = (m_st == 3) && !m_rp;
            e_vec = e_res && m_vec;
            e_rd  = reg_sel ? {6'b0, m_cause} : m_ctl;
            chk(cur_req, {core_clk_en, int_rst, resume_pulse, take_vector, exit_cause, reg_rdata},
                         {e_clk, e_rst, e_res, e_vec, m_cause, e_rd});
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL timeout R1 act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = v;
        tick(1);
        reg_wr = 1'b0;
    endtask

    // counts negedges with the core clock off; ends at the RESUME negedge
    task automatic count_off(output int n, output bit saw_rst);
        n = 0; saw_rst = 0;
        @(negedge clk);
        while (!core_clk_en && n < 5000) begin
            n++;
            if (int_rst) saw_rst = 1;
            @(negedge clk);
        end
    endtask

    task automatic realign();
        @(posedge clk);
        #2;
    endtask

    initial begin
        int n;
        bit sr;
        tick(2);
        cmp_on = 1'b1;
        // R6: reset state
        @(negedge clk);
        chk("R6", {int_rst, core_clk_en}, 2'b10);
        chk("R6", reg_rdata, 8'h00);
        realign();
        rst_n = 1'b1;
        count_off(n, sr);
        chk("R6", n, 1 << RLOG);
        chk("R6", {resume_pulse, exit_cause}, 3'b000);
        realign();

        // R9 / R1 / R4 / R2 / R3 / R7 / R10: external wake with vector
        cur_req = "R9";
        wr_ctl(8'hA0);
        @(negedge clk); chk("R9", reg_rdata, 8'hA0); realign();
        wr_ctl(8'h00);
        gie = 1'b1;
        cur_req = "R1";
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        @(negedge clk); chk("R1", core_clk_en, 0); realign();
        cur_req = "R4";
        wdt_event = 1'b1; wdt_ie = 1'b1;
        reg_wr = 1'b1; reg_wdata = 8'h1F;      // write while stopped
        tick(8);
        reg_wr = 1'b0; wdt_event = 1'b0; wdt_ie = 1'b0;
        tick(3);
        @(negedge clk);
        chk("R4", core_clk_en, 0);
        chk("R9", reg_rdata, 8'h00);
        realign();
        cur_req = "R2";
        ext_wake = 1'b1;
        count_off(n, sr);
        chk("R3", n, 256 + 3);
        chk("R7", {resume_pulse, take_vector}, 2'b11);
        chk("R2", exit_cause, 2'b01);
        @(negedge clk); chk("R7", resume_pulse, 0);
        realign();
        ext_wake = 1'b0;
        reg_sel = 1'b1;
        @(negedge clk); chk("R10", reg_rdata, 8'h01); realign();
        reg_sel = 1'b0;

        // R4 / R7: watchdog interrupt wake, tap 1, gie low
        cur_req = "R4";
        wr_ctl(8'h05);
        gie = 1'b0; wdt_ie = 1'b0;
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        wdt_event = 1'b1; tick(8);
        @(negedge clk); chk("R4", core_clk_en, 0); realign();
        cur_req = "R7";
        wdt_event = 1'b0; tick(3);
        wdt_ie = 1'b1; wdt_event = 1'b1;
        count_off(n, sr);
        chk("R3", n, 512 + 3);
        chk("R7", {resume_pulse, take_vector, exit_cause}, 4'b1010);
        realign();
        wdt_event = 1'b0; tick(3);

        // R5 / R8: watchdog reset beats external
        cur_req = "R5";
        wr_ctl(8'h03);
        gie = 1'b1;
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        tick(2);
        ext_wake = 1'b1; wdt_event = 1'b1;
        count_off(n, sr);
        chk("R5", n, (1 << RLOG) + 3);
        chk("R5", sr, 1);
        chk("R8", {resume_pulse, int_rst, exit_cause}, 4'b0010);
        chk("R5", reg_rdata, 8'h00);
        realign();
        ext_wake = 1'b0; wdt_event = 1'b0; tick(3);

        // R8: external beats watchdog interrupt
        cur_req = "R8";
        wr_ctl(8'h01);
        wdt_ie = 1'b1; gie = 1'b1;
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        tick(2);
        ext_wake = 1'b1; wdt_event = 1'b1;
        count_off(n, sr);
        chk("R8", n, 256 + 3);
        chk("R8", {resume_pulse, take_vector, exit_cause}, 4'b1101);
        realign();
        ext_wake = 1'b0; wdt_event = 1'b0;
        tick(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule